// File: doc/BRIEF.md
# Inbound Requester-to-Partition Mapper

This block sits on the inbound side of a host bridge and sorts every upstream transaction into an isolation partition. Three kinds of traffic come in: DMA requests, MSI writes and error messages. Each carries a 16-bit bus/device/function requester ID, and each also carries an address and data. A local table, loaded by software through a write port, turns the requester ID into a partition number. All three kinds use that same table.

Each kind is then handled on its own terms:

- **DMA** requests are tagged with the partition and with a window select. The window select is a single high address bit that picks one of two DMA windows.
- **MSI** writes are recognised only inside two fixed address pages. Inside a page, the write is decoded into an interrupt number, and a second table of interrupt descriptors gives that interrupt's owning partition. The interrupt is raised only when the owner matches the requester's partition. A mismatch drops the write and latches a sticky violation record.
- **Error messages** are only tagged with the partition.

The block has no translation of DMA addresses and no interrupt controller.

Top module: `rid_pe_mapper`

## Requirements
- R1: A request accepted with a valid kind produces `out_vld` exactly one cycle later, with all result fields in that same cycle.
- R2: The partition number comes from the requester table for every kind. The table is indexed by the low `RID_IDX_W` (8) bits of the requester ID, and higher ID bits do not affect the lookup.
- R3: A write with `cfg_sel`=0 loads the requester table, and a write with `cfg_sel`=1 loads the interrupt descriptor table. A lookup in the same cycle as a write to the same entry returns the value held before that write.
- R4: For kind 0 (DMA), `out_win` equals request address bit 59. For every other kind, `out_win` is 0.
- R5: Kind 1 (MSI) is recognised only when address bits 63:16 equal 0x0000_0000_FFFF or 0x0010_0000_0000. An MSI outside both pages gives `out_drop`=1 and `out_irq_fire`=0, and it does not touch the violation record.
- R6: The interrupt number is address bits 12:2 plus data bits 10:0. A sum of 2048 or more is rejected with `out_drop`, without recording a violation, and in that case `out_irq` reads 0.
- R7: A decoded MSI raises `out_irq_fire` only if the descriptor partition of its interrupt equals the requester's partition. Otherwise it raises `out_drop`.
- R8: An authorization mismatch sets `viol_flag` one cycle after its `out_drop`, and records the requester ID and interrupt number. A later mismatch does not overwrite a set record. `viol_clr` clears the flag, but a mismatch in the same cycle as `viol_clr` wins and is recorded.
- R9: Kind 3 is reserved and produces no output (`out_vld` stays 0).
- R10: Kind 2 (error) yields only the partition: `out_irq`=0, `out_win`=0, no fire and no drop.
- R11: After reset, `out_vld`, `out_irq_fire`, `out_drop` and `viol_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 = requester table, 1 = interrupt descriptor table |
| cfg_addr | input | 11 | Table entry index |
| cfg_wdata | input | 8 | Partition number to store |
| req_vld | input | 1 | Inbound request valid |
| req_kind | input | 2 | 0 DMA, 1 MSI, 2 error, 3 reserved |
| req_rid | input | 16 | Requester bus/device/function |
| req_addr | input | 64 | Request address |
| req_data | input | 32 | Request data (MSI payload) |
| viol_clr | input | 1 | Clears the violation record |
| out_vld | output | 1 | Result valid |
| out_kind | output | 2 | Kind of the result |
| out_pe | output | 8 | Partition number of the requester |
| out_win | output | 1 | DMA window select |
| out_irq | output | 11 | Decoded interrupt number |
| out_irq_fire | output | 1 | Authorized interrupt request |
| out_drop | output | 1 | MSI rejected |
| viol_flag | output | 1 | Sticky authorization violation |
| viol_rid | output | 16 | Requester ID of the recorded violation |
| viol_irq | output | 11 | Interrupt number of the recorded violation |

## Verification
The bench targets the interrupt-number boundary of 2047 against 2048. A design with an off-by-one range check would fire an out-of-range interrupt, or would drop the last valid one. It also targets the same-cycle write and lookup on one table entry. A design without read-first tables would report the new partition a cycle early. The violation record is exercised with a second mismatch while the record is set, and with a mismatch coinciding with a clear. A design that overwrote the record, or let the clear win, would report the wrong requester. Window misses and range overflows are checked to leave the violation record untouched, and upper requester ID bits are checked to be ignored.

// File: rtl/rid_map_pkg.sv
package rid_map_pkg;
    typedef enum logic [1:0] {
        KIND_DMA  = 2'd0,
        KIND_MSI  = 2'd1,
        KIND_ERR  = 2'd2,
        KIND_RSVD = 2'd3
    } req_kind_e;

    // Address bits 63:16 of the page just below 4 GiB that accepts MSI writes.
    localparam logic [47:0] MSI_LO_PAGE = 48'h0000_0000_FFFF;
endpackage

// File: rtl/pe_lut_ram.sv
module pe_lut_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Read-first: a read and a write to one entry in the same cycle return the old value.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/msi_irq_decode.sv
module msi_irq_decode import rid_map_pkg::*; #(
    parameter int          IRQ_W       = 11,
    parameter logic [47:0] MSI_HI_PAGE = 48'h0010_0000_0000
) (
    input  logic [47:0]      page,
    input  logic [IRQ_W-1:0] base,
    input  logic [IRQ_W-1:0] vec,
    output logic             page_hit,
    output logic             in_range,
    output logic [IRQ_W-1:0] irq_num
);
    logic [IRQ_W:0] sum;

    always_comb begin
        page_hit = (page == MSI_LO_PAGE) || (page == MSI_HI_PAGE);
        sum      = {1'b0, base} + {1'b0, vec};
        in_range = ~sum[IRQ_W];
        irq_num  = sum[IRQ_W-1:0];
    end
endmodule

// File: rtl/rid_pe_mapper.sv
module rid_pe_mapper import rid_map_pkg::*; #(
    parameter int          RID_IDX_W   = 8,
    parameter int          PE_W        = 8,
    parameter int          IRQ_W       = 11,
    parameter int          WIN_BIT     = 59,
    parameter logic [47:0] MSI_HI_PAGE = 48'h0010_0000_0000,
    localparam int         CFG_AW      = (RID_IDX_W > IRQ_W) ? RID_IDX_W : IRQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [PE_W-1:0]   cfg_wdata,
    input  logic              req_vld,
    input  logic [1:0]        req_kind,
    input  logic [15:0]       req_rid,
    input  logic [63:0]       req_addr,
    input  logic [31:0]       req_data,
    input  logic              viol_clr,
    output logic              out_vld,
    output logic [1:0]        out_kind,
    output logic [PE_W-1:0]   out_pe,
    output logic              out_win,
    output logic [IRQ_W-1:0]  out_irq,
    output logic              out_irq_fire,
    output logic              out_drop,
    output logic              viol_flag,
    output logic [15:0]       viol_rid,
    output logic [IRQ_W-1:0]  viol_irq
);
    typedef struct packed {
        logic             vld;
        req_kind_e        kind;
        logic [15:0]      rid;
        logic             win;
        logic [IRQ_W-1:0] irq;
        logic             msi_ok;
    } stage_t;

    typedef struct packed {
        stage_t           stg;
        logic             vflag;
        logic [15:0]      vrid;
        logic [IRQ_W-1:0] virq;
    } regs_t;

    regs_t            r_d, r_q;
    req_kind_e        kind_in;
    logic             page_hit, in_range;
    logic [IRQ_W-1:0] irq_num;
    logic [PE_W-1:0]  rid_pe, desc_pe;
    logic             is_msi_q, auth, viol_ev;
    logic             unused_bits;

    assign kind_in     = req_kind_e'(req_kind);
    assign unused_bits = ^{req_data, req_rid, cfg_addr, req_addr};

    msi_irq_decode #(.IRQ_W(IRQ_W), .MSI_HI_PAGE(MSI_HI_PAGE)) dec_i (
        .page     (req_addr[63:16]),
        .base     (req_addr[IRQ_W+1:2]),
        .vec      (req_data[IRQ_W-1:0]),
        .page_hit (page_hit),
        .in_range (in_range),
        .irq_num  (irq_num)
    );

    pe_lut_ram #(.AW(RID_IDX_W), .DW(PE_W)) rid_tab_i (
        .clk   (clk),
        .we    (cfg_we & ~cfg_sel),
        .waddr (cfg_addr[RID_IDX_W-1:0]),
        .wdata (cfg_wdata),
        .raddr (req_rid[RID_IDX_W-1:0]),
        .rdata (rid_pe)
    );

    pe_lut_ram #(.AW(IRQ_W), .DW(PE_W)) desc_tab_i (
        .clk   (clk),
        .we    (cfg_we & cfg_sel),
        .waddr (cfg_addr[IRQ_W-1:0]),
        .wdata (cfg_wdata),
        .raddr (irq_num),
        .rdata (desc_pe)
    );

    always_comb begin
        is_msi_q = r_q.stg.vld && (r_q.stg.kind == KIND_MSI);
        auth     = (desc_pe == rid_pe);
        viol_ev  = is_msi_q && r_q.stg.msi_ok && !auth;

        r_d     = r_q;
        r_d.stg = '0;
        if (req_vld && kind_in != KIND_RSVD) begin
            r_d.stg.vld    = 1'b1;
            r_d.stg.kind   = kind_in;
            r_d.stg.rid    = req_rid;
            r_d.stg.win    = (kind_in == KIND_DMA) ? req_addr[WIN_BIT] : 1'b0;
            r_d.stg.msi_ok = (kind_in == KIND_MSI) && page_hit && in_range;
            r_d.stg.irq    = r_d.stg.msi_ok ? irq_num : '0;
        end

        if (viol_ev && (!r_q.vflag || viol_clr)) begin
            r_d.vflag = 1'b1;
            r_d.vrid  = r_q.stg.rid;
            r_d.virq  = r_q.stg.irq;
        end else if (viol_clr) begin
            r_d.vflag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_vld      = r_q.stg.vld;
    assign out_kind     = r_q.stg.kind;
    assign out_pe       = r_q.stg.vld ? rid_pe : '0;
    assign out_win      = r_q.stg.win;
    assign out_irq      = r_q.stg.irq;
    assign out_irq_fire = is_msi_q && r_q.stg.msi_ok && auth;
    assign out_drop     = is_msi_q && !(r_q.stg.msi_ok && auth);
    assign viol_flag    = r_q.vflag;
    assign viol_rid     = r_q.vrid;
    assign viol_irq     = r_q.virq;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && req_kind != 2'd3 |=> out_vld);

    assert_reserved_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld || req_kind == 2'd3 |=> !out_vld);

    assert_dma_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && req_kind == 2'd0 |=> out_win == $past(req_addr[WIN_BIT]));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag && !viol_clr |=> viol_flag);

    assert_record_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag && !viol_clr |=> $stable(viol_rid) && $stable(viol_irq));

    assert_fire_is_msi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq_fire |-> out_vld && out_kind == 2'd1 && !out_drop);

    assert_error_plain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && out_kind == 2'd2 |-> !out_irq_fire && !out_drop && out_irq == '0);
endmodule

// File: tb/rid_pe_mapper_tb_top.sv
module rid_pe_mapper_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [10:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_vld = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_rid = '0;
    logic [63:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        viol_clr = 1'b0;
    logic        out_vld, out_win, out_irq_fire, out_drop, viol_flag;
    logic [1:0]  out_kind;
    logic [7:0]  out_pe;
    logic [10:0] out_irq, viol_irq;
    logic [15:0] viol_rid;

    rid_pe_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .req_vld(req_vld),
        .req_kind(req_kind), .req_rid(req_rid), .req_addr(req_addr),
        .req_data(req_data), .viol_clr(viol_clr), .out_vld(out_vld),
        .out_kind(out_kind), .out_pe(out_pe), .out_win(out_win),
        .out_irq(out_irq), .out_irq_fire(out_irq_fire), .out_drop(out_drop),
        .viol_flag(viol_flag), .viol_rid(viol_rid), .viol_irq(viol_irq)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int total = 0, bad = 0;
    bit done = 0;

    // Reference model state
    int rid_m [256];
    int desc_m [2048];
    int e_vld, e_kind, e_pe, e_win, e_irq, e_fire, e_drop, e_ok, e_auth, e_rid;
    int m_vflag, m_vrid, m_virq;

    localparam logic [63:0] LO_BASE = 64'h0000_0000_FFFF_0000;
    localparam logic [63:0] HI_BASE = 64'h0010_0000_0000_0000;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_vld = 0; e_kind = 0; e_pe = 0; e_win = 0; e_irq = 0;
            e_fire = 0; e_drop = 0; e_ok = 0; e_auth = 0; e_rid = 0;
            m_vflag = 0; m_vrid = 0; m_virq = 0;
        end else begin
            int k, v, hit, base, sum, pe, dpe;
            logic [47:0] page;
            // violation record update from the results shown this cycle
            if (e_vld != 0 && e_kind == 1 && e_ok != 0 && e_auth == 0 && (m_vflag == 0 || viol_clr)) begin
                m_vflag = 1; m_vrid = e_rid; m_virq = e_irq;
            end else if (viol_clr) begin
                m_vflag = 0;
            end
            // next results
            k    = int'(req_kind);
            v    = (req_vld && k != 3) ? 1 : 0;
            page = req_addr[63:16];
            hit  = (page == 48'h0000_0000_FFFF || page == 48'h0010_0000_0000) ? 1 : 0;
            base = int'(req_addr[12:2]);
            sum  = base + int'(req_data[10:0]);
            pe   = rid_m[req_rid[7:0]];
            dpe  = desc_m[sum % 2048];
            e_ok   = (v != 0 && k == 1 && hit != 0 && sum < 2048) ? 1 : 0;
            e_auth = (pe == dpe) ? 1 : 0;
            e_vld  = v;
            e_kind = v != 0 ? k : 0;
            e_pe   = v != 0 ? pe : 0;
            e_win  = (v != 0 && k == 0) ? int'(req_addr[59]) : 0;
            e_irq  = e_ok != 0 ? sum : 0;
            e_rid  = v != 0 ? int'(req_rid) : 0;
            e_fire = (e_ok != 0 && e_auth != 0) ? 1 : 0;
            e_drop = (v != 0 && k == 1 && e_fire == 0) ? 1 : 0;
            if (cfg_we) begin
                if (cfg_sel) desc_m[cfg_addr] = int'(cfg_wdata);
                else         rid_m[cfg_addr[7:0]] = int'(cfg_wdata);
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "out_vld", out_vld, e_vld);
            if (e_vld != 0) begin
                chk("R2", "out_pe", out_pe, e_pe);
                chk("R1", "out_kind", out_kind, e_kind);
                chk("R4", "out_win", out_win, e_win);
                chk("R6", "out_irq", out_irq, e_irq);
            end
            chk("R7", "out_irq_fire", out_irq_fire, e_fire);
            chk("R5", "out_drop", out_drop, e_drop);
            chk("R8", "viol_flag", viol_flag, m_vflag);
            if (m_vflag != 0) begin
                chk("R8", "viol_rid", viol_rid, m_vrid);
                chk("R8", "viol_irq", viol_irq, m_virq);
            end
        end
    end

    task automatic wr(input bit sel, input int a, input int d);
        cfg_we = 1; cfg_sel = sel; cfg_addr = 11'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic req(input int k, input int rid, input logic [63:0] a, input int d);
        req_vld = 1; req_kind = 2'(k); req_rid = 16'(rid); req_addr = a; req_data = 32'(d);
        @(negedge clk);
        req_vld = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 100000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "out_vld reset", out_vld, 0);
        chk("R11", "viol_flag reset", viol_flag, 0);
        chk("R11", "fire/drop reset", {out_irq_fire, out_drop}, 0);
        rst_n = 1;
        idle();

        for (int i = 0; i < 256; i++) wr(0, i, (i * 7 + 3) & 255);
        for (int i = 0; i < 2048; i++) wr(1, i, (i * 5 + 1) & 255);
        wr(0, 'h12, 'h40);
        wr(1, 100, 'h40);
        wr(1, 2047, 'h40);
        wr(1, 200, 'h41);

        req(0, 'h12, 64'h0, 0);
        chk("R2", "dma pe", out_pe, 'h40);
        chk("R4", "dma win0", out_win, 0);
        req(0, 'h12, 64'h1 << 59, 0);
        chk("R4", "dma win1", out_win, 1);
        req(2, 'h0112, 64'hFFFF_FFFF_FFFF_FFFF, 'h7FF);
        chk("R2", "upper rid bits ignored", out_pe, 'h40);
        chk("R10", "error plain", {out_win, out_irq_fire, out_drop, out_irq}, 0);
        req(3, 'h12, LO_BASE, 100);
        chk("R9", "reserved no output", out_vld, 0);

        req(1, 'h12, LO_BASE, 100);
        chk("R7", "low page fire", out_irq_fire, 1);
        chk("R6", "low page irq", out_irq, 100);
        req(1, 'h12, HI_BASE + 64'(50 * 4), 50);
        chk("R7", "high page fire", out_irq_fire, 1);
        chk("R6", "high page irq", out_irq, 100);

        req(1, 'h12, 64'h0000_0000_FFFE_0000, 100);
        chk("R5", "miss drop", out_drop, 1);
        idle();
        chk("R5", "miss no violation", viol_flag, 0);
        req(1, 'h12, LO_BASE + 64'(2047 * 4), 1);
        chk("R6", "2048 rejected", {out_drop, out_irq_fire}, 2'b10);
        idle();
        chk("R6", "overflow no violation", viol_flag, 0);
        req(1, 'h12, LO_BASE + 64'(2047 * 4), 0);
        chk("R6", "2047 accepted", out_irq, 2047);
        chk("R7", "2047 fires", out_irq_fire, 1);

        req(1, 'h12, LO_BASE, 200);
        chk("R7", "unauthorized drop", out_drop, 1);
        idle();
        chk("R8", "flag set", viol_flag, 1);
        chk("R8", "rid recorded", viol_rid, 'h12);
        chk("R8", "irq recorded", viol_irq, 200);
        req(1, 'h34, LO_BASE, 200);
        idle();
        chk("R8", "first record kept", viol_rid, 'h12);
        viol_clr = 1; idle(); viol_clr = 0;
        chk("R8", "cleared", viol_flag, 0);
        req(1, 'h12, LO_BASE, 200);
        idle();
        req(1, 'h34, LO_BASE, 200);
        viol_clr = 1; idle(); viol_clr = 0;
        chk("R8", "set wins over clear", viol_flag, 1);
        chk("R8", "new record", viol_rid, 'h34);
        viol_clr = 1; idle(); viol_clr = 0;

        cfg_we = 1; cfg_sel = 0; cfg_addr = 11'h55; cfg_wdata = 8'h99;
        req_vld = 1; req_kind = 2'd0; req_rid = 16'h55; req_addr = '0;
        @(negedge clk);
        cfg_we = 0; req_vld = 0;
        chk("R3", "read-first old value", out_pe, (85 * 7 + 3) & 255);
        req(0, 'h55, 64'h0, 0);
        chk("R3", "new value after write", out_pe, 'h99);
        wr(1, 300, 'h99);
        req(1, 'h55, LO_BASE + 64'(100 * 4), 200);
        chk("R3", "descriptor write used", out_irq_fire, 1);

        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [63:0] a;
            sel = int'($urandom % 4);
            case (sel)
                0: a = LO_BASE + 64'({$urandom} % 65536);
                1: a = HI_BASE + 64'({$urandom} % 65536);
                2: a = {$urandom, $urandom};
                default: a = {$urandom % 2 == 0 ? 32'h0800_0000 : 32'h0, $urandom};
            endcase
            req_vld  = ($urandom % 5) != 0;
            req_kind = 2'($urandom);
            req_rid  = 16'($urandom % 512);
            req_addr = a;
            req_data = $urandom;
            cfg_we   = ($urandom % 8) == 0;
            cfg_sel  = 1'($urandom);
            cfg_addr = 11'($urandom % 2048);
            cfg_wdata = 8'($urandom % 4);
            viol_clr = ($urandom % 16) == 0;
            @(negedge clk);
        end
        req_vld = 0; cfg_we = 0; viol_clr = 0;
        idle();
        idle();
        finish_run();
    end
endmodule